// File: doc/BRIEF.md
# Beam spill phase sequencer

This block steps a repeating accelerator beam spill through a fixed series of timed phases: a wait state, then accelerate, prepare, spill read (the window in which trigger candidates are accepted), post readout and flush, and back to wait. Every phase length is a programmable count of millisecond ticks. The ticks come from the system clock through a programmable prescaler.

A spill can be launched in several ways, and a mode field picks which one is active. The options are an internal periodic soft-spill timer, the rising edge of an external TTL input, a pulse from the network timing receiver, the first of TTL or network (automatic mode), the rising edge of a gate level, or continuous operation (infinite mode). A start request that arrives while a spill is in progress has no effect.

Software sets the phase durations, the timer period, the gate extension, the tick divider and the control word through a simple write port. It reads back a status word, a spill counter and the running soft-timer value. While the soft-reset bit in the control word is set, the sequencer, counters and timers are held cleared.

Top module: `spill_phase_seq`

## Requirements
- R1: After `rst`, the phase field is 0, the spill counter is 0, the soft timer is 0 and the source field is 0.
- R2: The phase field (status bits 12:8) takes only the values 0 wait, 1 accelerate, 2 prepare, 4 spill read, 8 post readout and 16 flush. A spill steps through them in the order 1, 2, 4, 8, 16 and then returns to 0.
- R3: Configuration word addresses are: 0 accelerate, 1 prepare, 2 spill read, 3 post readout and 4 flush durations (in ms); 5 gate extension (ms); 6 control; 7 soft period (ms); 8 clocks per ms tick. Each phase lasts its programmed number of ticks. A phase entered from wait may lose up to one tick period from its first tick. The reset durations are 10, 10, 3000, 10 and 970 ms, the gate extension is 100 ms and the soft period is 5000 ms.
- R4: Control bits 4:1 hold the mode. Mode 1 starts a spill when the soft timer expires, 2 on a rising edge of `ttl_in`, 3 on a `net_evt` pulse, 7 on whichever of those two comes first, 8 on a rising edge of `gate_in`, and 4 at once from wait. Mode 0 and every other value start nothing.
- R5: In mode 1 the soft timer counts ms ticks from 0 to the period minus 1. It then wraps to 0 and issues a start at that wrap. In any other mode it reads 0.
- R6: The spill counter increments by one on each entry into accelerate, and at no other time.
- R7: A start request that arrives outside the wait phase is ignored and does not change the counter.
- R8: In mode 4, spill read holds as long as the mode stays 4. After the mode changes, spill read lasts its programmed duration counted from the change, and no new spill starts in mode 0.
- R9: In mode 8, spill read holds while `gate_in` is high. It ends after the gate extension time has passed since `gate_in` fell.
- R10: While control bit 0 is set, the phase, spill counter, soft timer and tick prescaler are held at 0 and no spill starts.
- R11: Status bits 5:4 show the source. In modes 1, 2 and 3 they show the mode number. In mode 7 they show 2 or 3, according to whether the last spill was started by TTL or by the network, and 0 before any start. In all other modes they show 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | DW | Configuration write data |
| ttl_in | input | 1 | External TTL spill trigger, synchronous |
| net_evt | input | 1 | One-cycle network timing start event |
| gate_in | input | 1 | Spill gate level |
| status_o | output | 16 | Phase in bits 12:8, source in bits 5:4, others 0 |
| spill_cnt_o | output | CW | Number of spills started since reset |
| timer_ms_o | output | DW | Current soft-timer value in ms |

## Verification
The bench builds the block with `TICK_DIV` set to 4, so one millisecond is four clocks. It leaves every other parameter at its default. With this setting the reset-value accelerate duration of 10 ms takes only 40 clocks and can be measured directly. Small programmed durations, gate extensions and soft periods then fit in a few dozen clocks. This makes it possible to check every phase length, the wrap of the soft timer and the release of the infinite and gate holds with exact tick windows.

// File: rtl/spill_seq_pkg.sv
`timescale 1ns/1ps
package spill_seq_pkg;
  typedef enum logic [4:0] {
    PH_WAIT  = 5'd0,
    PH_ACCEL = 5'd1,
    PH_PREP  = 5'd2,
    PH_READ  = 5'd4,
    PH_POST  = 5'd8,
    PH_FLUSH = 5'd16
  } phase_t;

  localparam logic [3:0] MODE_OFF  = 4'd0;
  localparam logic [3:0] MODE_SOFT = 4'd1;
  localparam logic [3:0] MODE_TTL  = 4'd2;
  localparam logic [3:0] MODE_NET  = 4'd3;
  localparam logic [3:0] MODE_INF  = 4'd4;
  localparam logic [3:0] MODE_AUTO = 4'd7;
  localparam logic [3:0] MODE_GATE = 4'd8;

  localparam logic [1:0] SRC_NONE = 2'd0;
  localparam logic [1:0] SRC_SOFT = 2'd1;
  localparam logic [1:0] SRC_TTL  = 2'd2;
  localparam logic [1:0] SRC_NET  = 2'd3;

  localparam int REG_ACCEL  = 0;
  localparam int REG_PREP   = 1;
  localparam int REG_READ   = 2;
  localparam int REG_POST   = 3;
  localparam int REG_FLUSH  = 4;
  localparam int REG_GEXT   = 5;
  localparam int REG_CTRL   = 6;
  localparam int REG_PERIOD = 7;
  localparam int REG_DIV    = 8;
  localparam int NUM_REGS   = 9;
endpackage

// File: rtl/spill_cfg_regs.sv
`timescale 1ns/1ps
module spill_cfg_regs
  import spill_seq_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int TICK_DIV    = 100000,
  parameter int DUR_ACCEL   = 10,
  parameter int DUR_PREP    = 10,
  parameter int DUR_READ    = 3000,
  parameter int DUR_POST    = 10,
  parameter int DUR_FLUSH   = 970,
  parameter int GATE_EXT    = 100,
  parameter int SOFT_PERIOD = 5000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] regs_q [NUM_REGS]
);
  localparam logic [DW-1:0] RST_VAL [NUM_REGS] = '{
    DW'(DUR_ACCEL), DW'(DUR_PREP), DW'(DUR_READ), DW'(DUR_POST),
    DW'(DUR_FLUSH), DW'(GATE_EXT), DW'(0), DW'(SOFT_PERIOD), DW'(TICK_DIV)
  };

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        regs_q[i] <= RST_VAL[i];
      else if (we && addr == AW'(i))
        regs_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/spill_ms_tick.sv
`timescale 1ns/1ps
module spill_ms_tick #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [DW-1:0] div,
  output logic          tick_o
);
  logic [DW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pre_q  <= '0;
      tick_o <= 1'b0;
    end else if (pre_q + 1'b1 >= div) begin
      pre_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spill_start_src.sv
`timescale 1ns/1ps
module spill_start_src
  import spill_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          tick,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] period,
  input  logic          ttl_in,
  input  logic          net_evt,
  input  logic          gate_in,
  output logic          start_o,
  output logic [1:0]    start_src_o,
  output logic [DW-1:0] timer_o
);
  logic ttl_q, gate_q;
  logic ttl_rise, gate_rise, soft_fire;

  assign ttl_rise  = ttl_in & ~ttl_q;
  assign gate_rise = gate_in & ~gate_q;
  assign soft_fire = (mode == MODE_SOFT) && tick && (timer_o + 1'b1 >= period);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ttl_q   <= 1'b0;
      gate_q  <= 1'b0;
      timer_o <= '0;
    end else begin
      ttl_q  <= ttl_in;
      gate_q <= gate_in;
      if (mode != MODE_SOFT)
        timer_o <= '0;
      else if (tick)
        timer_o <= soft_fire ? '0 : timer_o + 1'b1;
    end
  end

  always_comb begin
    start_o     = 1'b0;
    start_src_o = SRC_NONE;
    case (mode)
      MODE_SOFT: begin start_o = soft_fire; start_src_o = SRC_SOFT; end
      MODE_TTL:  begin start_o = ttl_rise;  start_src_o = SRC_TTL;  end
      MODE_NET:  begin start_o = net_evt;   start_src_o = SRC_NET;  end
      MODE_INF:  start_o = 1'b1;
      MODE_AUTO: begin
        start_o     = ttl_rise | net_evt;
        start_src_o = ttl_rise ? SRC_TTL : SRC_NET;
      end
      MODE_GATE: start_o = gate_rise;
      default:   start_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spill_phase_fsm.sv
`timescale 1ns/1ps
module spill_phase_fsm
  import spill_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          tick,
  input  logic [3:0]    mode,
  input  logic          start,
  input  logic [1:0]    start_src,
  input  logic          gate_in,
  input  logic [DW-1:0] dur_accel,
  input  logic [DW-1:0] dur_prep,
  input  logic [DW-1:0] dur_read,
  input  logic [DW-1:0] dur_post,
  input  logic [DW-1:0] dur_flush,
  input  logic [DW-1:0] gate_ext,
  output phase_t        phase_o,
  output logic [CW-1:0] count_o,
  output logic [1:0]    last_src_o
);
  logic [DW-1:0] dcnt_q, dcnt_inc, dur_cur;
  logic          freeze;
  phase_t        ph_next;

  function automatic phase_t follow(input phase_t p);
    case (p)
      PH_ACCEL: follow = PH_PREP;
      PH_PREP:  follow = PH_READ;
      PH_READ:  follow = PH_POST;
      PH_POST:  follow = PH_FLUSH;
      default:  follow = PH_WAIT;
    endcase
  endfunction

  assign dcnt_inc = dcnt_q + 1'b1;
  assign ph_next  = follow(phase_o);
  assign freeze   = (phase_o == PH_READ) &&
                    ((mode == MODE_INF) || (mode == MODE_GATE && gate_in));

  always_comb begin
    case (phase_o)
      PH_ACCEL: dur_cur = dur_accel;
      PH_PREP:  dur_cur = dur_prep;
      PH_READ:  dur_cur = (mode == MODE_GATE) ? gate_ext : dur_read;
      PH_POST:  dur_cur = dur_post;
      default:  dur_cur = dur_flush;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase_o    <= PH_WAIT;
      dcnt_q     <= '0;
      count_o    <= '0;
      last_src_o <= SRC_NONE;
    end else if (phase_o == PH_WAIT) begin
      if (start) begin
        phase_o    <= PH_ACCEL;
        dcnt_q     <= '0;
        count_o    <= count_o + 1'b1;
        last_src_o <= start_src;
      end
    end else if (freeze) begin
      dcnt_q <= '0;
    end else if (tick) begin
      if (dcnt_inc >= dur_cur) begin
        phase_o <= ph_next;
        dcnt_q  <= '0;
      end else begin
        dcnt_q <= dcnt_inc;
      end
    end
  end
endmodule

// File: rtl/spill_phase_seq.sv
`timescale 1ns/1ps
module spill_phase_seq
  import spill_seq_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CW          = 32,
  parameter int AW          = 4,
  parameter int TICK_DIV    = 100000,
  parameter int DUR_ACCEL   = 10,
  parameter int DUR_PREP    = 10,
  parameter int DUR_READ    = 3000,
  parameter int DUR_POST    = 10,
  parameter int DUR_FLUSH   = 970,
  parameter int GATE_EXT    = 100,
  parameter int SOFT_PERIOD = 5000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ttl_in,
  input  logic          net_evt,
  input  logic          gate_in,
  output logic [15:0]   status_o,
  output logic [CW-1:0] spill_cnt_o,
  output logic [DW-1:0] timer_ms_o
);
  logic [DW-1:0] cfg_q [NUM_REGS];
  logic          soft_rst, tick, start;
  logic [3:0]    mode;
  logic [1:0]    start_src, last_src, src_field;
  phase_t        phase;
  logic          unused_ctrl;

  spill_cfg_regs #(
    .DW(DW), .AW(AW), .TICK_DIV(TICK_DIV),
    .DUR_ACCEL(DUR_ACCEL), .DUR_PREP(DUR_PREP), .DUR_READ(DUR_READ),
    .DUR_POST(DUR_POST), .DUR_FLUSH(DUR_FLUSH), .GATE_EXT(GATE_EXT),
    .SOFT_PERIOD(SOFT_PERIOD)
  ) i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .regs_q(cfg_q)
  );

  assign soft_rst    = cfg_q[REG_CTRL][0];
  assign mode        = cfg_q[REG_CTRL][4:1];
  assign unused_ctrl = ^cfg_q[REG_CTRL][DW-1:5];

  spill_ms_tick #(.DW(DW)) i_tick (
    .clk(clk), .rst(rst), .hold(soft_rst), .div(cfg_q[REG_DIV]), .tick_o(tick)
  );

  spill_start_src #(.DW(DW)) i_src (
    .clk(clk), .rst(rst), .hold(soft_rst), .tick(tick), .mode(mode),
    .period(cfg_q[REG_PERIOD]), .ttl_in(ttl_in), .net_evt(net_evt),
    .gate_in(gate_in), .start_o(start), .start_src_o(start_src),
    .timer_o(timer_ms_o)
  );

  spill_phase_fsm #(.DW(DW), .CW(CW)) i_fsm (
    .clk(clk), .rst(rst), .hold(soft_rst), .tick(tick), .mode(mode),
    .start(start), .start_src(start_src), .gate_in(gate_in),
    .dur_accel(cfg_q[REG_ACCEL]), .dur_prep(cfg_q[REG_PREP]),
    .dur_read(cfg_q[REG_READ]), .dur_post(cfg_q[REG_POST]),
    .dur_flush(cfg_q[REG_FLUSH]), .gate_ext(cfg_q[REG_GEXT]),
    .phase_o(phase), .count_o(spill_cnt_o), .last_src_o(last_src)
  );

  always_comb begin
    case (mode)
      MODE_SOFT, MODE_TTL, MODE_NET: src_field = mode[1:0];
      MODE_AUTO:                     src_field = last_src;
      default:                       src_field = SRC_NONE;
    endcase
  end

  assign status_o = {3'b000, phase, 2'b00, src_field, 4'b0000};
endmodule

// File: rtl/spill_seq_checker.sv
`timescale 1ns/1ps
module spill_seq_checker #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic [15:0]   status,
  input logic [CW-1:0] cnt,
  input logic [DW-1:0] timer
);
  logic [4:0] ph;
  assign ph = status[12:8];

  a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ph));

  a_r2_wait_exits_to_accel: assert property (@(posedge clk) disable iff (rst)
    ($past(ph) == 5'd0 && ph != 5'd0) |-> ph == 5'd1);

  a_r2_phase_order: assert property (@(posedge clk) disable iff (rst)
    (ph != $past(ph) && !soft_rst && $past(ph) != 5'd0)
      |-> ph == (($past(ph) == 5'd16) ? 5'd0 : ($past(ph) << 1)));

  a_r6_count_on_accel: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt) && !soft_rst)
      |-> (ph == 5'd1 && $past(ph) == 5'd0 && cnt == $past(cnt) + 1'b1));

  a_r10_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ph == 5'd0 && cnt == '0 && timer == '0));

  a_r5_timer_steps: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && !$stable(timer)) |-> (timer == '0 || timer == $past(timer) + 1'b1));
endmodule

bind spill_phase_seq spill_seq_checker #(.DW(DW), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .status(status_o),
  .cnt(spill_cnt_o), .timer(timer_ms_o)
);

// File: tb/test_spill_phase_seq.sv
`timescale 1ns/1ps
module test_spill_phase_seq;
  localparam int DIV = 4;

  // row: {mode, stimulus (0 none,1 ttl,2 net,3 gate), source field, start expected}
  localparam logic [15:0] VEC [12] = '{
    16'h0100, 16'h1011, 16'h2121, 16'h2220, 16'h3231, 16'h3130,
    16'h7121, 16'h7231, 16'h8301, 16'h8100, 16'h4001, 16'h5100
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ttl_in = 1'b0, net_evt = 1'b0, gate_in = 1'b0;
  logic [15:0] status;
  logic [31:0] cnt, timer;
  logic [4:0]  phase;
  int checks = 0, errors = 0;

  assign phase = status[12:8];
  always #2.5 clk = ~clk;

  spill_phase_seq #(.TICK_DIV(DIV)) i_spill_phase_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ttl_in(ttl_in), .net_evt(net_evt),
    .gate_in(gate_in), .status_o(status), .spill_cnt_o(cnt), .timer_ms_o(timer)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl(input int mode, input int srst);
    wr(6, (mode << 1) | srst);
  endtask

  task automatic restart(input int mode);
    set_ctrl(mode, 1);
    set_ctrl(mode, 0);
  endtask

  task automatic stim(input int kind);
    @(negedge clk);
    if (kind == 1) ttl_in = 1'b1;
    if (kind == 2) net_evt = 1'b1;
    if (kind == 3) gate_in = 1'b1;
    @(negedge clk);
    ttl_in = 1'b0; net_evt = 1'b0;
  endtask

  task automatic measure(input logic [4:0] code, output int n);
    n = 0;
    while (phase == code && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && phase != 5'd0; k++) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n, maxt;
    int durs [5] = '{2, 3, 4, 2, 3};
    logic [4:0] codes [5] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd16};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 phase after reset", phase, 0);
    check("R1 count after reset", cnt, 0);
    check("R1 timer after reset", timer, 0);
    check("R1 source after reset", status[5:4], 0);

    // R3 reset-value accelerate duration (10 ms)
    set_ctrl(2, 0);
    stim(1);
    check("R2 accel entered", phase, 1);
    check("R6 count on accel entry", cnt, 1);
    measure(5'd1, n);
    check_range("R3 default accel 10 ms", n, 9*DIV + 1, 10*DIV);

    // R4/R11 start source table
    wr(0, 20);
    wr(7, 3);
    for (int r = 0; r < 12; r++) begin
      gate_in = 1'b0;
      restart(int'(VEC[r][15:12]));
      stim(int'(VEC[r][11:8]));
      repeat (24) @(negedge clk);
      check($sformatf("R4 start row %0d", r), int'(phase != 5'd0), int'(VEC[r][0]));
      check($sformatf("R6 count row %0d", r), cnt, int'(VEC[r][0]));
      check($sformatf("R11 source row %0d", r), status[5:4], int'(VEC[r][7:4]));
    end
    gate_in = 1'b0;

    // R5 soft timer wraps at period
    wr(7, 5);
    restart(1);
    maxt = 0;
    for (int k = 0; k < 36; k++) begin
      @(negedge clk);
      if (timer > maxt) maxt = timer;
    end
    check("R5 timer peak period-1", maxt, 4);
    check("R5 one soft start", cnt, 1);

    // R10 soft reset holds everything
    set_ctrl(1, 1);
    @(negedge clk);
    check("R10 phase cleared", phase, 0);
    check("R10 count cleared", cnt, 0);
    check("R10 timer cleared", timer, 0);
    repeat (40) @(negedge clk);
    check("R10 no start while held", cnt, 0);
    check("R10 timer held", timer, 0);

    // R2/R3 full sequence with programmed durations
    for (int i = 0; i < 5; i++) wr(i, durs[i]);
    restart(2);
    stim(1);
    for (int i = 0; i < 5; i++) begin
      check($sformatf("R2 phase code step %0d", i), phase, codes[i]);
      measure(codes[i], n);
      check_range($sformatf("R3 phase %0d length", codes[i]), n,
                  (durs[i] - 1)*DIV + 1, durs[i]*DIV);
    end
    check("R2 back to wait", phase, 0);
    check("R6 count after spill", cnt, 1);

    // R7 second start during active spill
    restart(2);
    stim(1);
    stim(1);
    check("R7 still accel", phase, 1);
    wait_idle();
    check("R7 count unchanged", cnt, 1);

    // R8 infinite mode
    restart(4);
    repeat (70) @(negedge clk);
    check("R8 held in spill read", phase, 4);
    set_ctrl(0, 0);
    measure(5'd4, n);
    check_range("R8 read after mode change", n, 12, 17);
    check("R8 post readout follows", phase, 8);
    wait_idle();
    repeat (20) @(negedge clk);
    check("R8 no restart in mode 0", cnt, 1);

    // R9 gate mode
    wr(5, 3);
    restart(8);
    stim(3);
    repeat (60) @(negedge clk);
    check("R9 held while gate high", phase, 4);
    gate_in = 1'b0;
    measure(5'd4, n);
    check_range("R9 gate extension length", n, 8, 13);
    check("R9 post readout follows", phase, 8);

    finish_up();
  end
endmodule